// File: doc/BRIEF.md
# Sharer-Chain Invalidation Node

This block is the coherence controller of one node in a system where remote memory blocks are cached at node level and the nodes holding a clean copy of a block are linked in a singly linked sharer chain. For every tracked line it holds a stable state: invalid, read-only (a clean copy that other nodes may also hold) or read-write (the only, owned copy). Next to the state it keeps the node ID of the following chain member. It also holds a flag recording that the local side has asked home for ownership of the line and has not yet got it.

Invalidation messages arrive one at a time. The node drops or claims its copy and sends the message on to the next chain member, or sends an acknowledgement to home if it is the last member. A selective invalidation starts with an owner field of zero, the null ID. The first chain member that has an ownership request outstanding writes its own ID into that field and keeps the line as read-write. Every member after it sees a non-zero owner and gives up its copy. Home never needs to know how many ownership requests are in flight. A node that loses keeps its request flag, so it can reissue the request.

Node ID zero is the null ID and never names a node. A next pointer of zero marks the tail of the chain. The output message is registered and appears one cycle after the input message.

Top module: `sinv_node`

## Requirements
- R1: After reset every line is invalid, with a zero next pointer and a clear request flag, and no output message is valid.
- R2: A fill (fill_valid) writes the line's state and next pointer and clears its request flag. fill_state 1 means read-only, 2 means read-write, and any other value means invalid. A fill in the same cycle as an incoming message to the same line is dropped.
- R3: A local ownership request (req_valid) sets the request flag only when the line is read-only. On an invalid or read-write line it has no effect.
- R4: A message with in_kind other than 1 is a plain invalidation. The line becomes invalid with a zero next pointer and its request flag unchanged. The message goes on with kind 0, the owner field unchanged, to a destination that is never zero.
- R5: When the line's next pointer is zero, the output has kind 2 (acknowledge), its destination is home_id, and it carries the owner field as it stands after this node.
- R6: A selective invalidation (in_kind 1) with owner 0 that reaches a read-only line whose request flag is set makes the line read-write and clears the flag. The owner field goes out as my_id and the message goes on as kind 1.
- R7: A selective invalidation with a non-zero owner invalidates the line, keeps the request flag and sends the owner field on unchanged.
- R8: A selective invalidation with owner 0 on a line with no request flag invalidates the line and sends owner 0 on.
- R9: An ownership request in the same cycle as a null-owner selective invalidation to the same read-only line counts as outstanding, and the node claims the line.
- R10: out_valid is high in exactly the cycle after a cycle with in_valid high.
- R11: In a chain of nodes where several members have requests outstanding, a selective invalidation started at the head leaves exactly one member read-write. That member is the requester nearest the head, and the acknowledgement names it. Every other requester keeps its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | 3 | This node's ID (non-zero) |
| home_id | input | 3 | Home node ID for acknowledgements |
| fill_valid | input | 1 | Install a line |
| fill_idx | input | 2 | Line to install |
| fill_state | input | 2 | 1 read-only, 2 read-write, other invalid |
| fill_next | input | 3 | Next chain member, 0 for tail |
| req_valid | input | 1 | Local ownership request |
| req_idx | input | 2 | Line of the request |
| in_valid | input | 1 | Incoming message valid |
| in_kind | input | 2 | 1 selective, other plain invalidation |
| in_idx | input | 2 | Line addressed |
| in_owner | input | 3 | Owner field, 0 null |
| out_valid | output | 1 | Outgoing message valid |
| out_kind | output | 2 | 0 plain, 1 selective, 2 acknowledge |
| out_dest | output | 3 | Destination node ID |
| out_idx | output | 2 | Line addressed |
| out_owner | output | 3 | Owner field after this node |
| q_idx | input | 2 | Line to observe |
| q_state | output | 2 | 0 invalid, 1 read-only, 2 read-write |
| q_pend | output | 1 | Request flag of the observed line |
| q_next | output | 3 | Next pointer of the observed line |

## Verification
Two functions can meet in one cycle: a local ownership request and an incoming null-owner selective invalidation to the same line. A directed case drives both on the same clock edge. It expects the acknowledgement to carry the node's own ID, the line to end read-write and the flag to end clear. A second collision, a fill meeting an invalidation on one line, is provoked the same way and judged by the line ending invalid. Random chains of four nodes, with random list orders, requester sets and hop delays, check that the claim goes to the first requester in list order.

// File: rtl/sinv_pkg.sv
package sinv_pkg;

    parameter int unsigned NODE_ID_W = 3;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_RO  = 2'd1,
        ST_RW  = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        MSG_INV = 2'd0,
        MSG_SEL = 2'd1,
        MSG_ACK = 2'd2
    } msg_kind_e;

    typedef struct packed {
        line_st_e               state;
        logic [NODE_ID_W-1:0]   next;
        logic                   pend;
    } line_rec_t;

    typedef struct packed {
        msg_kind_e              kind;
        logic [NODE_ID_W-1:0]   dest;
        logic [NODE_ID_W-1:0]   owner;
    } msg_t;

    localparam line_rec_t LINE_RESET = '{state: ST_INV, next: '0, pend: 1'b0};

    function automatic line_st_e decode_fill(input logic [1:0] code);
        case (code)
            2'd1:    return ST_RO;
            2'd2:    return ST_RW;
            default: return ST_INV;
        endcase
    endfunction

    function automatic logic is_tail(input logic [NODE_ID_W-1:0] nxt);
        return (nxt == '0);
    endfunction

endpackage

// File: rtl/sinv_line_store.sv
module sinv_line_store
    import sinv_pkg::*;
#(
    parameter int unsigned LINES = 4,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fill_valid,
    input  logic [IDX_W-1:0]      fill_idx,
    input  line_st_e              fill_state,
    input  logic [NODE_ID_W-1:0]  fill_next,
    input  logic                  req_valid,
    input  logic [IDX_W-1:0]      req_idx,
    input  logic                  upd_valid,
    input  logic [IDX_W-1:0]      upd_idx,
    input  line_st_e              upd_state,
    input  logic                  upd_pend,
    input  logic [IDX_W-1:0]      rd_a_idx,
    output line_rec_t             rd_a_rec,
    input  logic [IDX_W-1:0]      rd_b_idx,
    output line_rec_t             rd_b_rec
);

    line_rec_t recs [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic hit_upd, hit_fill, hit_req;
        line_rec_t r;

        assign hit_upd  = upd_valid  && (upd_idx  == IDX_W'(i));
        assign hit_fill = fill_valid && (fill_idx == IDX_W'(i));
        assign hit_req  = req_valid  && (req_idx  == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= LINE_RESET;
            end else if (hit_upd) begin
                r.state <= upd_state;
                r.next  <= '0;
                r.pend  <= upd_pend;
            end else if (hit_fill) begin
                r.state <= fill_state;
                r.next  <= (fill_state == ST_INV) ? '0 : fill_next;
                r.pend  <= 1'b0;
            end else if (hit_req && r.state == ST_RO) begin
                r.pend  <= 1'b1;
            end
        end

        assign recs[i] = r;
    end

    assign rd_a_rec = recs[rd_a_idx];
    assign rd_b_rec = recs[rd_b_idx];

endmodule

// File: rtl/sinv_decide.sv
module sinv_decide
    import sinv_pkg::*;
(
    input  line_rec_t             rec,
    input  logic [1:0]            in_kind,
    input  logic [NODE_ID_W-1:0]  in_owner,
    input  logic                  req_same,
    input  logic [NODE_ID_W-1:0]  my_id,
    input  logic [NODE_ID_W-1:0]  home_id,
    output line_st_e              upd_state,
    output logic                  upd_pend,
    output msg_t                  out_msg
);

    logic      is_sel;
    logic      pend_eff;
    logic      claim;
    msg_kind_e fwd_kind;

    always_comb begin
        is_sel   = (in_kind == 2'd1);
        pend_eff = rec.pend || (req_same && rec.state == ST_RO);
        claim    = is_sel && (in_owner == '0) && pend_eff && (rec.state == ST_RO);
        fwd_kind = is_sel ? MSG_SEL : MSG_INV;

        upd_state = claim ? ST_RW : ST_INV;
        upd_pend  = claim ? 1'b0 : pend_eff;

        out_msg.owner = claim ? my_id : in_owner;
        if (is_tail(rec.next)) begin
            out_msg.kind = MSG_ACK;
            out_msg.dest = home_id;
        end else begin
            out_msg.kind = fwd_kind;
            out_msg.dest = rec.next;
        end
    end

endmodule

// File: rtl/sinv_out_reg.sv
module sinv_out_reg
    import sinv_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  msg_t              in_msg,
    input  logic [IDX_W-1:0]  in_idx,
    output logic              out_valid,
    output msg_t              out_msg,
    output logic [IDX_W-1:0]  out_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_msg   <= '{kind: MSG_INV, dest: '0, owner: '0};
            out_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_msg <= in_msg;
                out_idx <= in_idx;
            end
        end
    end

endmodule

// File: rtl/sinv_node.sv
module sinv_node
    import sinv_pkg::*;
#(
    parameter int unsigned LINES = 4,
    parameter int unsigned ID_W  = NODE_ID_W,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   my_id,
    input  logic [ID_W-1:0]   home_id,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [1:0]        fill_state,
    input  logic [ID_W-1:0]   fill_next,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [ID_W-1:0]   in_owner,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [ID_W-1:0]   out_dest,
    output logic [IDX_W-1:0]  out_idx,
    output logic [ID_W-1:0]   out_owner,
    input  logic [IDX_W-1:0]  q_idx,
    output logic [1:0]        q_state,
    output logic              q_pend,
    output logic [ID_W-1:0]   q_next
);

    line_rec_t cur_rec, obs_rec;
    line_st_e  upd_state;
    logic      upd_pend;
    logic      req_same;
    msg_t      nxt_msg, reg_msg;

    assign req_same = req_valid && (req_idx == in_idx);

    sinv_line_store #(.LINES(LINES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_state (decode_fill(fill_state)),
        .fill_next  (fill_next),
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .upd_valid  (in_valid),
        .upd_idx    (in_idx),
        .upd_state  (upd_state),
        .upd_pend   (upd_pend),
        .rd_a_idx   (in_idx),
        .rd_a_rec   (cur_rec),
        .rd_b_idx   (q_idx),
        .rd_b_rec   (obs_rec)
    );

    sinv_decide u_decide (
        .rec       (cur_rec),
        .in_kind   (in_kind),
        .in_owner  (in_owner),
        .req_same  (req_same),
        .my_id     (my_id),
        .home_id   (home_id),
        .upd_state (upd_state),
        .upd_pend  (upd_pend),
        .out_msg   (nxt_msg)
    );

    sinv_out_reg #(.IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_msg    (nxt_msg),
        .in_idx    (in_idx),
        .out_valid (out_valid),
        .out_msg   (reg_msg),
        .out_idx   (out_idx)
    );

    assign out_kind  = reg_msg.kind;
    assign out_dest  = reg_msg.dest;
    assign out_owner = reg_msg.owner;

    assign q_state = obs_rec.state;
    assign q_pend  = obs_rec.pend;
    assign q_next  = obs_rec.next;

endmodule

// File: rtl/sinv_node_chk.sv
module sinv_node_chk #(
    parameter int unsigned ID_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [ID_W-1:0]  my_id,
    input logic [ID_W-1:0]  home_id,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic [ID_W-1:0]  in_owner,
    input logic             out_valid,
    input logic [1:0]       out_kind,
    input logic [ID_W-1:0]  out_dest,
    input logic [ID_W-1:0]  out_owner
);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);

    assert_out_follows_in_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_out_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_ack_to_home_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd2) |-> (out_dest == $past(home_id)));

    assert_fwd_dest_nonnull_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 2'd2) |-> (out_dest != '0));

    assert_plain_keeps_owner_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind != 2'd1) |=> (out_owner == $past(in_owner) && out_kind != 2'd1));

    assert_taken_owner_passes_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd1 && in_owner != '0) |=> (out_owner == $past(in_owner)));

    assert_claim_uses_own_id_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd1) |=>
            (out_owner == $past(in_owner) || out_owner == $past(my_id)));

endmodule

bind sinv_node sinv_node_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .my_id     (my_id),
    .home_id   (home_id),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_owner  (in_owner),
    .out_valid (out_valid),
    .out_kind  (out_kind),
    .out_dest  (out_dest),
    .out_owner (out_owner)
);

// File: tb/sinv_node_tb.sv
module sinv_node_tb;

    localparam int NN   = 4;
    localparam int HOME = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NN-1:0] fill_v, req_v, in_v;
    logic [1:0]    line_sel;
    logic [1:0]    fill_st;
    logic [2:0]    fill_nx [NN];
    logic [1:0]    in_kind;
    logic [2:0]    in_owner;

    logic          out_v     [NN];
    logic [1:0]    out_kind  [NN];
    logic [2:0]    out_dest  [NN];
    logic [1:0]    out_idx   [NN];
    logic [2:0]    out_owner [NN];
    logic [1:0]    q_state   [NN];
    logic          q_pend    [NN];
    logic [2:0]    q_next    [NN];

    for (genvar g = 0; g < NN; g++) begin : g_node
        sinv_node u_dut (
            .clk        (clk),
            .rst        (rst),
            .my_id      (3'(g + 1)),
            .home_id    (3'(HOME)),
            .fill_valid (fill_v[g]),
            .fill_idx   (line_sel),
            .fill_state (fill_st),
            .fill_next  (fill_nx[g]),
            .req_valid  (req_v[g]),
            .req_idx    (line_sel),
            .in_valid   (in_v[g]),
            .in_kind    (in_kind),
            .in_idx     (line_sel),
            .in_owner   (in_owner),
            .out_valid  (out_v[g]),
            .out_kind   (out_kind[g]),
            .out_dest   (out_dest[g]),
            .out_idx    (out_idx[g]),
            .out_owner  (out_owner[g]),
            .q_idx      (line_sel),
            .q_state    (q_state[g]),
            .q_pend     (q_pend[g]),
            .q_next     (q_next[g])
        );
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int first_req(input int ord [NN], input logic [NN-1:0] mask);
        for (int k = 0; k < NN; k++) if (mask[ord[k]]) return ord[k];
        return -1;
    endfunction

    task automatic idle();
        fill_v = '0; req_v = '0; in_v = '0;
    endtask

    // Fill one node's line, then go idle
    task automatic fill_one(input int n, input logic [1:0] st, input logic [2:0] nx);
        @(negedge clk);
        fill_v = '0; fill_v[n] = 1'b1; fill_st = st; fill_nx[n] = nx;
        @(negedge clk);
        idle();
    endtask

    task automatic req_mask(input logic [NN-1:0] m);
        @(negedge clk);
        req_v = m;
        @(negedge clk);
        idle();
    endtask

    // Deliver a message to node n; sample its output one cycle later
    task automatic deliver(input int n, input logic [1:0] k, input logic [2:0] o);
        @(negedge clk);
        in_v = '0; in_v[n] = 1'b1; in_kind = k; in_owner = o;
        @(negedge clk);
        in_v = '0;
        chk(out_v[n] == 1'b1, "R10 out_valid", int'(out_v[n]), 1);
    endtask

    // Behavioural queue: walk a message along the chain until it reaches home
    task automatic run_chain(input int head, input logic [1:0] kind, input logic [2:0] own,
                             output int ack_owner, output int hops);
        int cur = head;
        logic [1:0] k = kind;
        logic [2:0] o = own;
        bit done = 0;
        hops = 0;
        ack_owner = -1;
        while (!done && hops < 2 * NN) begin
            deliver(cur, k, o);
            hops++;
            if (out_kind[cur] == 2'd2) begin
                chk(out_dest[cur] == 3'(HOME), "R5 ack dest", int'(out_dest[cur]), HOME);
                ack_owner = int'(out_owner[cur]);
                done = 1;
            end else begin
                chk(out_dest[cur] != 3'd0 && out_dest[cur] <= 3'(NN), "R4 fwd dest",
                    int'(out_dest[cur]), 1);
                k = out_kind[cur];
                o = out_owner[cur];
                cur = int'(out_dest[cur]) - 1;
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
        end
        chk(done, "R5 chain reaches home", hops, NN);
    endtask

    // Build a chain for line_sel in order ord, set requests in mask
    task automatic build_chain(input int ord [NN], input logic [NN-1:0] mask);
        @(negedge clk);
        fill_v = '1; fill_st = 2'd1;
        for (int k = 0; k < NN; k++)
            fill_nx[ord[k]] = (k < NN - 1) ? 3'(ord[k + 1] + 1) : 3'd0;
        @(negedge clk);
        idle();
        if (mask != '0) req_mask(mask);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int ord [NN];
        int ackw, hops, win;
        logic [NN-1:0] mask;
        void'($urandom(32'd2024));
        idle();
        line_sel = 2'd0; fill_st = 2'd0; in_kind = 2'd0; in_owner = 3'd0;
        for (int n = 0; n < NN; n++) fill_nx[n] = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state on every line of every node
        for (int l = 0; l < 4; l++) begin
            line_sel = 2'(l);
            #1;
            for (int n = 0; n < NN; n++) begin
                chk(q_state[n] == 2'd0, "R1 state", int'(q_state[n]), 0);
                chk(q_pend[n] == 1'b0 && q_next[n] == 3'd0, "R1 pend/next",
                    int'(q_pend[n]), 0);
                chk(out_v[n] == 1'b0, "R1 out_valid", int'(out_v[n]), 0);
            end
        end

        // R3: request on an invalid line has no effect
        line_sel = 2'd1;
        req_mask(4'b0001);
        chk(q_pend[0] == 1'b0, "R3 req on invalid", int'(q_pend[0]), 0);
        // R3: request on a read-write line has no effect
        fill_one(0, 2'd2, 3'd0);
        chk(q_state[0] == 2'd2, "R2 fill rw", int'(q_state[0]), 2);
        req_mask(4'b0001);
        chk(q_pend[0] == 1'b0, "R3 req on rw", int'(q_pend[0]), 0);
        // R3: request on a read-only line sets the flag
        fill_one(0, 2'd1, 3'd0);
        req_mask(4'b0001);
        chk(q_pend[0] == 1'b1, "R3 req on ro", int'(q_pend[0]), 1);
        // R2: a new fill clears the flag and writes the pointer
        fill_one(0, 2'd1, 3'd3);
        chk(q_pend[0] == 1'b0, "R2 fill clears pend", int'(q_pend[0]), 0);
        chk(q_next[0] == 3'd3, "R2 fill next", int'(q_next[0]), 3);

        // R7: taken owner passes unchanged, copy lost, flag kept
        fill_one(0, 2'd1, 3'd0);
        req_mask(4'b0001);
        deliver(0, 2'd1, 3'd5);
        chk(out_kind[0] == 2'd2 && out_owner[0] == 3'd5, "R7 owner kept",
            int'(out_owner[0]), 5);
        chk(q_state[0] == 2'd0 && q_pend[0] == 1'b1, "R7 inv, pend kept",
            int'({q_state[0], q_pend[0]}), 1);

        // R9: request and null selective in the same cycle -> claim
        fill_one(0, 2'd1, 3'd0);
        @(negedge clk);
        in_v = 4'b0001; req_v = 4'b0001; in_kind = 2'd1; in_owner = 3'd0;
        @(negedge clk);
        idle();
        chk(out_v[0] && out_kind[0] == 2'd2 && out_owner[0] == 3'd1, "R9 same-cycle claim",
            int'(out_owner[0]), 1);
        chk(q_state[0] == 2'd2 && q_pend[0] == 1'b0, "R9 state rw",
            int'(q_state[0]), 2);
        @(negedge clk);
        chk(out_v[0] == 1'b0, "R10 single pulse", int'(out_v[0]), 0);

        // R2: fill colliding with a message to the same line is dropped
        line_sel = 2'd2;
        @(negedge clk);
        in_v = 4'b0001; fill_v = 4'b0001; fill_st = 2'd2; fill_nx[0] = 3'd2;
        in_kind = 2'd0; in_owner = 3'd0;
        @(negedge clk);
        idle();
        chk(q_state[0] == 2'd0 && q_next[0] == 3'd0, "R2 fill dropped",
            int'(q_state[0]), 0);
        chk(out_kind[0] == 2'd2, "R5 tail acks", int'(out_kind[0]), 2);

        // R4 and R8: plain invalidation and null selective without requests
        line_sel = 2'd3;
        ord = '{0, 1, 2, 3};
        build_chain(ord, 4'b0110);
        run_chain(0, 2'd0, 3'd0, ackw, hops);
        chk(ackw == 0 && hops == NN, "R4 plain chain ack owner", ackw, 0);
        for (int n = 0; n < NN; n++) begin
            chk(q_state[n] == 2'd0, "R4 all invalid", int'(q_state[n]), 0);
            chk(q_pend[n] == ((n == 1 || n == 2) ? 1'b1 : 1'b0), "R4 pend kept",
                int'(q_pend[n]), (n == 1 || n == 2) ? 1 : 0);
        end
        build_chain(ord, 4'b0000);
        run_chain(0, 2'd1, 3'd0, ackw, hops);
        chk(ackw == 0, "R8 no claimant", ackw, 0);
        for (int n = 0; n < NN; n++)
            chk(q_state[n] == 2'd0, "R8 all invalid", int'(q_state[n]), 0);

        // R6 / R11: random chains with random requester sets
        for (int t = 0; t < 48; t++) begin
            int rot = $urandom_range(0, NN - 1);
            bit rev = 1'($urandom_range(0, 1));
            line_sel = 2'($urandom_range(0, 3));
            for (int k = 0; k < NN; k++)
                ord[k] = rev ? ((rot - k + NN) % NN) : ((rot + k) % NN);
            mask = (t < 2) ? 4'b1111 : 4'($urandom_range(0, 15));
            build_chain(ord, mask);
            win = first_req(ord, mask);
            run_chain(ord[0], 2'd1, 3'd0, ackw, hops);
            chk(ackw == win + 1, "R11 ack names first requester", ackw, win + 1);
            for (int n = 0; n < NN; n++) begin
                chk(q_state[n] == ((n == win) ? 2'd2 : 2'd0), "R6 R11 final state",
                    int'(q_state[n]), (n == win) ? 2 : 0);
                chk(q_pend[n] == ((mask[n] && n != win) ? 1'b1 : 1'b0), "R11 loser keeps pend",
                    int'(q_pend[n]), (mask[n] && n != win) ? 1 : 0);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule